// File: doc/BRIEF.md
# Dual-Clock Word-to-Byte Stream Packetizer

This block moves 32-bit words from a producer running on an accumulator clock to a byte-wide AXI4-Stream master running on a separate network clock. A run starts with a one-cycle start pulse that carries a word count. The block then pulls words from its producer in fixed batches of 256. It asks for each batch with a one-cycle request pulse, and the producer answers with exactly 256 valid words, which may come with gaps between them.

On the network side, each complete batch becomes one 1024-byte packet. The packetizer waits until a whole batch sits in its clock-crossing FIFO and the transmitter reports that it is ready. It then raises a one-cycle transmit request and streams the words out least significant byte first. The transmitter enables tready only after it has seen the request. When every requested word has been accepted downstream, the block gives a one-cycle completion pulse in the accumulator domain. A count that is not a multiple of 256 is rounded up to whole batches.

The FIFO holds two batches, so the request for the next batch can overlap the drain of the current packet. Word pointers cross the clock domains in Gray code through two-flop synchronizers.

Top module: `byte_packetizer`

## Requirements
- R1: Each word is emitted as four bytes in the order bits [7:0], [15:8], [23:16], [31:24], and words leave in the order they were written.
- R2: batchReq is a single-cycle pulse. A new batchReq is issued only after all 256 words of the previous batch have been written.
- R3: runCount is captured on the runStart pulse, and later changes on runCount have no effect. A run issues exactly ceil(count/256) batch requests, and a count of zero issues none.
- R4: wordValid is ignored while no batch is open: before the first batchReq, between batches and after the last batch. Such words never reach the stream.
- R5: txReq is a single-cycle pulse, raised only in a cycle that follows one where txReqReady was high. It precedes each 1024-byte packet, and mAxisTvalid is never high outside a requested packet.
- R6: Each byte is transferred once, on a cycle where mAxisTvalid and mAxisTready are both high. While mAxisTvalid is high and the byte has not been accepted, mAxisTvalid stays high and mAxisTdata stays unchanged. mAxisTvalid is low when no byte is pending.
- R7: runDone is a single-cycle pulse. It comes only after the last byte of the last batch has been accepted, and exactly once per run.
- R8: The FIFO holds two batches. A second batch can be requested before any byte of the first has been accepted, and batch n+2 is never requested before 1024·n bytes have been accepted.
- R9: The asynchronous reset arst clears the FIFO, the counters and the byte lane, returning both domains to idle. Words held at reset are never emitted afterwards.
- R10: A runStart pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accClk | input | 1 | Accumulator-domain clock |
| netClk | input | 1 | Network-domain clock |
| arst | input | 1 | Asynchronous reset, active high, for both domains |
| runStart | input | 1 | One-cycle pulse (accClk) that starts a run |
| runCount | input | 32 | Words in the run, sampled with runStart |
| batchReq | output | 1 | One-cycle pulse (accClk) asking for 256 words |
| wordIn | input | 32 | Word from the producer |
| wordValid | input | 1 | wordIn is valid this accClk cycle |
| runDone | output | 1 | One-cycle pulse (accClk) when the run has drained |
| txReqReady | input | 1 | Transmitter can take a new packet request (netClk) |
| txReq | output | 1 | One-cycle packet request pulse (netClk) |
| mAxisTdata | output | 8 | Stream byte |
| mAxisTvalid | output | 1 | Stream byte valid |
| mAxisTready | input | 1 | Stream byte accepted by the transmitter |

## Verification
A corrupted write or read pointer, or a wrong lane index, shows at the ports within one or two network cycles. The byte that appears differs from the byte the producer supplied at that position in the stream, or valid rises while nothing is pending. An accumulator-side counter that is off by even one word shows up in two ways: the number of batch requests for the run is wrong, or the run finishes with bytes missing or left over. A stuck completion path shows as a missing runDone once the stream has fallen silent. A lost pointer update after reset shows as stale bytes at the start of the next run.

// File: rtl/pktz_pkg.sv
package pktz_pkg;

  // Strobes from the control logic to the datapath.
  typedef struct packed {
    logic wrEn;      // accClk: push wordIn into the FIFO
    logic byteTake;  // netClk: current byte accepted downstream
  } pktzStrobes_t;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_CHECK,
    ACC_FILL,
    ACC_DRAIN
  } accState_t;

  typedef enum logic {
    NET_IDLE,
    NET_STREAM
  } netState_t;

endpackage

// File: rtl/pktz_sync.sv
module pktz_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or posedge arst) begin
        if (arst) stage[g] <= '0;
        else      stage[g] <= d;
      end
    end else begin : gNext
      always_ff @(posedge clk or posedge arst) begin
        if (arst) stage[g] <= '0;
        else      stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/pktz_datapath.sv
module pktz_datapath
  import pktz_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic              accClk,
  input  logic              netClk,
  input  logic              arst,
  input  pktzStrobes_t      strobes,
  input  logic [WORD_W-1:0] wordIn,
  output logic [ADDR_W:0]   accUsed,
  output logic [ADDR_W:0]   netAvail,
  output logic              laneLast,
  output logic [BYTE_W-1:0] byteOut
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [ADDR_W:0] DEPTH_LVL = (ADDR_W+1)'(DEPTH);

  function automatic logic [ADDR_W:0] grayToBin(input logic [ADDR_W:0] g);
    logic [ADDR_W:0] b;
    b[ADDR_W] = g[ADDR_W];
    for (int i = ADDR_W - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];

  logic [ADDR_W:0] wPtrBin, wPtrGray, wPtrNext;
  logic [ADDR_W:0] rPtrBin, rPtrGray, rPtrNext;
  logic [ADDR_W:0] wPtrGraySync, rPtrGraySync;
  logic [LANE_W-1:0] laneIdx;
  logic pop;

  // write side (accClk)
  assign wPtrNext = wPtrBin + (ADDR_W+1)'(1);

  always_ff @(posedge accClk or posedge arst) begin
    if (arst) begin
      wPtrBin  <= '0;
      wPtrGray <= '0;
    end else if (strobes.wrEn) begin
      wPtrBin  <= wPtrNext;
      wPtrGray <= wPtrNext ^ (wPtrNext >> 1);
    end
  end

  always_ff @(posedge accClk) begin
    if (strobes.wrEn) mem[wPtrBin[ADDR_W-1:0]] <= wordIn;
  end

  pktz_sync #(.W(ADDR_W+1), .STAGES(2)) uRdToAcc (
    .clk (accClk),
    .arst(arst),
    .d   (rPtrGray),
    .q   (rPtrGraySync)
  );

  assign accUsed = wPtrBin - grayToBin(rPtrGraySync);

  // read side (netClk)
  pktz_sync #(.W(ADDR_W+1), .STAGES(2)) uWrToNet (
    .clk (netClk),
    .arst(arst),
    .d   (wPtrGray),
    .q   (wPtrGraySync)
  );

  assign netAvail = grayToBin(wPtrGraySync) - rPtrBin;
  assign laneLast = (laneIdx == LANE_W'(LANES - 1));
  assign pop      = strobes.byteTake && laneLast;
  assign rPtrNext = rPtrBin + (ADDR_W+1)'(1);

  always_ff @(posedge netClk or posedge arst) begin
    if (arst) begin
      rPtrBin  <= '0;
      rPtrGray <= '0;
      laneIdx  <= '0;
    end else begin
      if (strobes.byteTake) laneIdx <= laneLast ? '0 : laneIdx + LANE_W'(1);
      if (pop) begin
        rPtrBin  <= rPtrNext;
        rPtrGray <= rPtrNext ^ (rPtrNext >> 1);
      end
    end
  end

  logic [WORD_W-1:0] rdWord;
  logic [BYTE_W-1:0] laneBytes [LANES];

  assign rdWord = mem[rPtrBin[ADDR_W-1:0]];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneBytes[g] = rdWord[g*BYTE_W +: BYTE_W];
  end

  assign byteOut = laneBytes[laneIdx];

  // R8: a write never lands on a full FIFO
  a_r8_no_overflow: assert property (@(posedge accClk) disable iff (arst)
    strobes.wrEn |-> (accUsed != DEPTH_LVL));

  // R6: no byte is taken from an empty FIFO
  a_r6_no_pop_empty: assert property (@(posedge netClk) disable iff (arst)
    strobes.byteTake |-> (netAvail != '0));

endmodule

// File: rtl/pktz_ctrl.sv
module pktz_ctrl
  import pktz_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int BATCH_WORDS = 256,
  parameter int ADDR_W      = 9
) (
  input  logic             accClk,
  input  logic             netClk,
  input  logic             arst,
  input  logic             runStart,
  input  logic [CNT_W-1:0] runCount,
  input  logic             wordValid,
  input  logic [ADDR_W:0]  accUsed,
  output logic             batchReq,
  output logic             runDone,
  input  logic             txReqReady,
  input  logic             mTready,
  input  logic [ADDR_W:0]  netAvail,
  input  logic             laneLast,
  output logic             txReq,
  output logic             mTvalid,
  output pktzStrobes_t     strobes
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int BATCH_W = (BATCH_WORDS > 1) ? $clog2(BATCH_WORDS) : 1;
  localparam int TOT_W   = CNT_W + 1;
  localparam logic [ADDR_W:0]    BATCH_LVL = (ADDR_W+1)'(BATCH_WORDS);
  localparam logic [ADDR_W:0]    DEPTH_LVL = (ADDR_W+1)'(DEPTH);
  localparam logic [BATCH_W-1:0] FILL_LAST = BATCH_W'(BATCH_WORDS - 1);
  localparam logic [TOT_W-1:0]   BATCH_INC = TOT_W'(BATCH_WORDS);

  // accumulator domain: batch sequencing
  accState_t        accState;
  logic [CNT_W-1:0] runTarget;
  logic [TOT_W-1:0] wordsIssued;
  logic [BATCH_W-1:0] batchFill;
  logic hasRoom, moreNeeded, wrEn, batchDone;

  assign hasRoom    = (DEPTH_LVL - accUsed) >= BATCH_LVL;
  assign moreNeeded = wordsIssued < {1'b0, runTarget};
  assign wrEn       = (accState == ACC_FILL) && wordValid;
  assign batchDone  = wrEn && (batchFill == FILL_LAST);

  always_ff @(posedge accClk or posedge arst) begin
    if (arst) begin
      accState    <= ACC_IDLE;
      runTarget   <= '0;
      wordsIssued <= '0;
      batchFill   <= '0;
      batchReq    <= 1'b0;
      runDone     <= 1'b0;
    end else begin
      batchReq <= 1'b0;
      runDone  <= 1'b0;
      unique case (accState)
        ACC_IDLE: begin
          if (runStart) begin
            runTarget   <= runCount;
            wordsIssued <= '0;
            accState    <= ACC_CHECK;
          end
        end
        ACC_CHECK: begin
          if (!moreNeeded) begin
            accState <= ACC_DRAIN;
          end else if (hasRoom) begin
            batchReq  <= 1'b1;
            batchFill <= '0;
            accState  <= ACC_FILL;
          end
        end
        ACC_FILL: begin
          if (wrEn) batchFill <= batchFill + BATCH_W'(1);
          if (batchDone) begin
            wordsIssued <= wordsIssued + BATCH_INC;
            accState    <= ACC_CHECK;
          end
        end
        ACC_DRAIN: begin
          if (accUsed == '0) begin
            runDone  <= 1'b1;
            accState <= ACC_IDLE;
          end
        end
        default: accState <= ACC_IDLE;
      endcase
    end
  end

  // network domain: packet request and streaming
  netState_t netState;
  logic [BATCH_W-1:0] pktWords;
  logic byteTake, pop;

  assign mTvalid  = (netState == NET_STREAM) && (netAvail != '0);
  assign byteTake = mTvalid && mTready;
  assign pop      = byteTake && laneLast;

  always_ff @(posedge netClk or posedge arst) begin
    if (arst) begin
      netState <= NET_IDLE;
      pktWords <= '0;
      txReq    <= 1'b0;
    end else begin
      txReq <= 1'b0;
      unique case (netState)
        NET_IDLE: begin
          if (netAvail >= BATCH_LVL && txReqReady) begin
            txReq    <= 1'b1;
            pktWords <= '0;
            netState <= NET_STREAM;
          end
        end
        NET_STREAM: begin
          if (pop) begin
            pktWords <= pktWords + BATCH_W'(1);
            if (pktWords == FILL_LAST) netState <= NET_IDLE;
          end
        end
        default: netState <= NET_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.wrEn     = wrEn;
    strobes.byteTake = byteTake;
  end

  // R2: batch request lasts one cycle
  a_r2_batch_pulse: assert property (@(posedge accClk) disable iff (arst)
    batchReq |=> !batchReq);

  // R7: completion lasts one cycle
  a_r7_done_pulse: assert property (@(posedge accClk) disable iff (arst)
    runDone |=> !runDone);

  // R5: request only after the transmitter was ready
  a_r5_req_gated: assert property (@(posedge netClk) disable iff (arst)
    txReq |-> $past(txReqReady));

  // R5: transmit request lasts one cycle
  a_r5_req_pulse: assert property (@(posedge netClk) disable iff (arst)
    txReq |=> !txReq);

  // R6: valid is held until accepted
  a_r6_valid_held: assert property (@(posedge netClk) disable iff (arst)
    (mTvalid && !mTready) |=> mTvalid);

endmodule

// File: rtl/byte_packetizer.sv
module byte_packetizer
  import pktz_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int CNT_W       = 32,
  parameter int BATCH_WORDS = 256,
  parameter int FIFO_ADDR_W = 9
) (
  input  logic              accClk,
  input  logic              netClk,
  input  logic              arst,
  input  logic              runStart,
  input  logic [CNT_W-1:0]  runCount,
  output logic              batchReq,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  output logic              runDone,
  input  logic              txReqReady,
  output logic              txReq,
  output logic [BYTE_W-1:0] mAxisTdata,
  output logic              mAxisTvalid,
  input  logic              mAxisTready
);

  pktzStrobes_t strobes;
  logic [FIFO_ADDR_W:0] accUsed;
  logic [FIFO_ADDR_W:0] netAvail;
  logic laneLast;

  pktz_ctrl #(
    .CNT_W      (CNT_W),
    .BATCH_WORDS(BATCH_WORDS),
    .ADDR_W     (FIFO_ADDR_W)
  ) uCtrl (
    .accClk    (accClk),
    .netClk    (netClk),
    .arst      (arst),
    .runStart  (runStart),
    .runCount  (runCount),
    .wordValid (wordValid),
    .accUsed   (accUsed),
    .batchReq  (batchReq),
    .runDone   (runDone),
    .txReqReady(txReqReady),
    .mTready   (mAxisTready),
    .netAvail  (netAvail),
    .laneLast  (laneLast),
    .txReq     (txReq),
    .mTvalid   (mAxisTvalid),
    .strobes   (strobes)
  );

  pktz_datapath #(
    .WORD_W(WORD_W),
    .BYTE_W(BYTE_W),
    .ADDR_W(FIFO_ADDR_W)
  ) uData (
    .accClk  (accClk),
    .netClk  (netClk),
    .arst    (arst),
    .strobes (strobes),
    .wordIn  (wordIn),
    .accUsed (accUsed),
    .netAvail(netAvail),
    .laneLast(laneLast),
    .byteOut (mAxisTdata)
  );

  // R6: an offered byte does not change before it is accepted
  a_r6_data_held: assert property (@(posedge netClk) disable iff (arst)
    (mAxisTvalid && !mAxisTready) |=> $stable(mAxisTdata));

endmodule

// File: tb/byte_packetizer_test.sv
module byte_packetizer_test;

  logic accClk = 1'b0;
  logic netClk = 1'b0;
  logic arst = 1'b1;
  logic runStart = 1'b0;
  logic [31:0] runCount = '0;
  logic batchReq;
  logic [31:0] wordIn = '0;
  logic wordValid = 1'b0;
  logic runDone;
  logic txReqReady = 1'b0;
  logic txReq;
  logic [7:0] mAxisTdata;
  logic mAxisTvalid;
  logic mAxisTready = 1'b0;

  always #10 netClk = ~netClk;   // 50 MHz
  always #16 accClk = ~accClk;

  byte_packetizer uut (
    .accClk(accClk), .netClk(netClk), .arst(arst),
    .runStart(runStart), .runCount(runCount), .batchReq(batchReq),
    .wordIn(wordIn), .wordValid(wordValid), .runDone(runDone),
    .txReqReady(txReqReady), .txReq(txReq),
    .mAxisTdata(mAxisTdata), .mAxisTvalid(mAxisTvalid), .mAxisTready(mAxisTready)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // producer model (accClk)
  int feedLeft = 0;
  int batchSeen = 0;
  bit gapMode = 0, junkMode = 0, doneSeen = 0, sawOverlap = 0, prevBatch = 0;
  logic [31:0] lcg = 32'h1234_5678;
  int accepted = 0;

  always @(negedge accClk) begin
    if (arst) begin
      feedLeft = 0; wordValid = 0; prevBatch = 0;
      expQ.delete();
    end else begin
      if (batchReq) begin
        check(!prevBatch, "R2", "batchReq longer than one cycle", 1, 0);
        check(feedLeft == 0, "R2", "batchReq while batch still open", feedLeft, 0);
        batchSeen++;
        check(accepted >= (batchSeen - 2) * 1024, "R8", "batch requested without room",
              accepted, (batchSeen - 2) * 1024);
        if (batchSeen == 2 && accepted == 0) sawOverlap = 1;
        feedLeft = 256;
      end
      prevBatch = batchReq;
      if (feedLeft > 0 && (!gapMode || lcg[5])) begin
        wordValid = 1;
        wordIn = lcg;
        expQ.push_back(lcg[7:0]);   expQ.push_back(lcg[15:8]);
        expQ.push_back(lcg[23:16]); expQ.push_back(lcg[31:24]);
        feedLeft--;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
      end else if (feedLeft == 0 && junkMode) begin
        wordValid = 1;
        wordIn = 32'hA5A5_0000 | (lcg >> 16);
        lcg = lcg * 32'd1664525 + 32'd1013904223;
      end else begin
        wordValid = 0;
        if (gapMode) lcg = lcg * 32'd1664525 + 32'd1013904223;
      end
      if (runDone) begin
        check(!doneSeen, "R7", "second runDone in one run", 1, 0);
        check(expQ.size() == 0, "R7", "runDone with bytes pending", expQ.size(), 0);
        check(accepted == batchSeen * 1024, "R7", "bytes accepted at runDone",
              accepted, batchSeen * 1024);
        doneSeen = 1;
      end
    end
  end

  // transmitter model and stream reference (netClk)
  bit pktOpen = 0, prevReady = 0, stallMode = 0, heldPrev = 0;
  int pktAge = 0, bytesInPkt = 0, holdOff = 0, netCycles = 0, blockUntil = 0, firstReq = -1;
  logic [7:0] heldData = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge netClk) begin
    netCycles++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (arst) begin
      pktOpen = 0; prevReady = 0; heldPrev = 0; bytesInPkt = 0;
      mAxisTready = 0; txReqReady = 0;
    end else begin
      if (txReq) begin
        check(prevReady, "R5", "txReq without txReqReady", 0, 1);
        check(!pktOpen, "R5", "txReq inside a packet", 1, 0);
        if (firstReq < 0) firstReq = netCycles;
        pktOpen = 1; pktAge = 0; bytesInPkt = 0;
      end
      if (pktOpen) pktAge++;
      mAxisTready = pktOpen && (pktAge > holdOff) && (!stallMode || lfsr[0] || lfsr[3]);
      if (mAxisTvalid) begin
        check(pktOpen, "R5", "tvalid outside a requested packet", 0, 1);
        check(expQ.size() != 0, "R6", "tvalid with nothing pending", 0, 1);
        if (heldPrev)
          check(mAxisTdata == heldData, "R6", "tdata changed while stalled", mAxisTdata, heldData);
        if (expQ.size() != 0)
          check(mAxisTdata == expQ[0], "R1", "stream byte", mAxisTdata, expQ[0]);
      end
      if (mAxisTvalid && mAxisTready && expQ.size() != 0) begin
        void'(expQ.pop_front());
        accepted++;
        bytesInPkt++;
        if (bytesInPkt == 1024) pktOpen = 0;
      end
      heldPrev = mAxisTvalid && !mAxisTready;
      heldData = mAxisTdata;
      txReqReady = !pktOpen && (netCycles >= blockUntil);
      prevReady = txReqReady;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge netClk) begin
    wd++;
    if (wd > 150000) begin
      check(0, "R7", "watchdog expired", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic startRun(input int cnt);
    batchSeen = 0; accepted = 0; doneSeen = 0; sawOverlap = 0; firstReq = -1;
    @(negedge accClk);
    runCount = cnt; runStart = 1;
    @(negedge accClk);
    runStart = 0; runCount = 32'hFFFF_FFFF;  // R3: later changes ignored
  endtask

  task automatic waitDone(input int expBatches, input string tag);
    for (int i = 0; i < 40000 && !doneSeen; i++) @(negedge accClk);
    check(doneSeen, "R7", {tag, " runDone seen"}, doneSeen, 1);
    check(batchSeen == expBatches, "R3", {tag, " batch count"}, batchSeen, expBatches);
    check(accepted == expBatches * 1024, "R6", {tag, " bytes accepted"}, accepted, expBatches * 1024);
    repeat (20) @(negedge accClk);
    check(!mAxisTvalid, "R6", {tag, " tvalid idle after run"}, mAxisTvalid, 0);
  endtask

  task automatic checkIdle(input string tag);
    check(!batchReq, "R9", {tag, " batchReq"}, batchReq, 0);
    check(!runDone, "R9", {tag, " runDone"}, runDone, 0);
    check(!txReq, "R9", {tag, " txReq"}, txReq, 0);
    check(!mAxisTvalid, "R9", {tag, " tvalid"}, mAxisTvalid, 0);
  endtask

  initial begin
    repeat (4) @(negedge accClk);
    checkIdle("reset");
    arst = 0;
    repeat (4) @(negedge accClk);

    // short run, transmitter not ready at first
    blockUntil = netCycles + 200;
    startRun(17);
    waitDone(1, "count17");
    check(firstReq >= blockUntil, "R5", "txReq while transmitter not ready", firstReq, blockUntil);

    // four batches, stalled stream, gappy producer
    stallMode = 1; gapMode = 1;
    startRun(1024);
    waitDone(4, "count1024");
    stallMode = 0; gapMode = 0;

    // overlap: transmitter holds tready low at the start of each packet
    holdOff = 3000;
    startRun(600);
    waitDone(3, "count600");
    check(sawOverlap, "R8", "second batch before first byte", sawOverlap, 1);
    holdOff = 0;

    // zero count
    startRun(0);
    waitDone(0, "count0");

    // junk words between batches, and a second start mid-run
    junkMode = 1;
    startRun(300);
    while (batchSeen < 1) @(negedge accClk);
    runCount = 5000; runStart = 1;
    @(negedge accClk);
    runStart = 0;
    waitDone(2, "count300");  // R4 and R10: junk ignored, restart ignored
    junkMode = 0;

    // reset in the middle of a run
    stallMode = 1;
    startRun(1024);
    while (accepted < 500) @(negedge accClk);
    arst = 1;
    repeat (3) @(negedge accClk);
    checkIdle("midrun reset");
    arst = 0;
    stallMode = 0;
    repeat (4) @(negedge accClk);
    checkIdle("after reset");
    startRun(17);
    waitDone(1, "post-reset count17");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule